// File: doc/BRIEF.md
# TDM Timeslot Data Access Unit

This block connects to a serial time-division-multiplexed frame bus with two data lines, one running upstream and one running downstream. The bus carries one bit per clock. A frame-sync pulse marks the first bit of a 12-slot frame. Each slot holds 8 bits, most significant bit first.

The block contains four byte-wide data registers, grouped into two pairs. Each data register can capture one chosen timeslot from one chosen line. Each data register can also drive its contents into one chosen timeslot on one chosen line. A small microcontroller register port gives access to every data, select and control register. Software can use this to monitor a channel, loop it back, move it to another slot, or rewrite a captured byte before it goes out again.

Each pair has a swap mode. In swap mode, the input selections of the two members are exchanged, which lets a pair switch two channels crosswise. The output selections are not affected by swap.

Top module: `tdm_slot_access`

## Requirements
- R1: Frame timing. A high `fsync` sample marks bit 0 of slot 0. Each slot is 8 clocks long and each frame is 96 clocks long. Serial bytes travel MSB first on both the receive side and the transmit side.
- R2: Select register layout. Bits 3:0 hold the timeslot and bit 4 selects the line (0 = upstream, 1 = downstream). A slot value from 12 to 15 selects no slot, so the register neither captures nor drives.
- R3: Capture without swap. When a register's input enable is set and its pair's swap bit is clear, the register loads the byte received on the last bit of the slot and line named by its own select register.
- R4: Capture with swap. When the swap bit is set, member 0 of the pair captures at the slot and line named by member 1's select register, and member 1 captures at the slot and line named by member 0's select register. The output slot and line of each member still come from its own select register.
- R5: Drive. When a register's output enable is set, its byte is sent MSB first during the selected slot on the selected line. The matching drive-enable output is high for exactly those 8 bits. The transmit outputs lag the bus position by one clock: the value for position p appears in the cycle after `fsync`/`rx` for position p were sampled. When the drive enable is low, the transmit bit is 0.
- R6: Input disable. When a register's input enable is clear, the register keeps its contents and ignores the bus.
- R7: Output disable. When a register's output enable is clear, it drives nothing. The register still captures if its input enable is set.
- R8: Register map. Offsets 0 to 3 are the data registers. Offsets 4 to 7 are the select registers, 5 bits wide. Offsets 8 and 9 are the controls for pairs 1 and 2, 5 bits wide: bit 0 is swap, bits 1 and 2 are the input enables of members 0 and 1, and bits 3 and 4 are the output enables of members 0 and 1. Read data is registered and appears one clock after the address. Unused bits and unused offsets read as 0. A byte written to a data register is driven out like a captured byte.
- R9: If a microcontroller write and a bus capture target the same data register in the same clock, the written value is kept.
- R10: Synchronous reset clears every register. After reset both drive enables are low and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bus bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | High on bit 0 of slot 0 |
| up_rx | input | 1 | Upstream line, received bit |
| dn_rx | input | 1 | Downstream line, received bit |
| up_tx | output | 1 | Upstream line, transmitted bit |
| up_tx_en | output | 1 | Upstream drive enable |
| dn_tx | output | 1 | Downstream line, transmitted bit |
| dn_tx_en | output | 1 | Downstream drive enable |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |

## Verification
The bench uses slots 0 and 11, the first and last slot of a frame, and a slot value of 13, which must produce neither a capture nor a drive. A design that counts the frame wrong, or that decodes an unused slot value, would show the byte in the wrong bits or on a line that should be idle. Swap cases run in both pairs, with input and output on different lines and in different slots. A design that also swaps the output selections would drive the wrong slot or line. A microcontroller write is timed to land on the exact clock of a capture; a design that gives the bus priority would read back the captured byte. Input-disable and output-disable runs change the bus byte after capture. A design that keeps capturing would expose the new byte, and one that ignores the output enable would raise a drive enable.

// File: rtl/tdm_sa_pkg.sv
package tdm_sa_pkg;

  // Line identifiers used by the select register port bit.
  localparam bit LINE_UP = 1'b0;
  localparam bit LINE_DN = 1'b1;

  // Per-pair control word, LSB first: swap, in0, in1, out0, out1.
  typedef struct packed {
    logic out1;
    logic out0;
    logic in1;
    logic in0;
    logic swap;
  } pair_ctrl_t;

  localparam int CTRL_W = $bits(pair_ctrl_t);

endpackage

// File: rtl/tdm_sa_frame_timer.sv
module tdm_sa_frame_timer #(
  parameter int SLOTS  = 12,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              last_bit_o
);

  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [BIT_W-1:0]  bit_q, bit_n;

  // Position of the bit currently on the bus; fsync forces slot 0 bit 0.
  always_comb begin
    slot_n = slot_q;
    bit_n  = bit_q + BIT_W'(1);
    if (fsync_i) begin
      slot_n = '0;
      bit_n  = '0;
    end else if (bit_q == BIT_W'(DATA_W - 1)) begin
      bit_n  = '0;
      slot_n = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_W'(SLOTS - 1);
      bit_q  <= BIT_W'(DATA_W - 1);
    end else begin
      slot_q <= slot_n;
      bit_q  <= bit_n;
    end
  end

  assign slot_o     = slot_n;
  assign bit_o      = bit_n;
  assign last_bit_o = (bit_n == BIT_W'(DATA_W - 1));

endmodule

// File: rtl/tdm_sa_line.sv
module tdm_sa_line #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int SLOT_W   = 4,
  parameter int BIT_W    = 3,
  parameter int SEL_W    = 5,
  parameter bit LINE_ID  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [SEL_W-1:0]  sel_i [NUM_REGS],
  input  logic [NUM_REGS-1:0] out_en_i,
  input  logic [DATA_W-1:0] data_i [NUM_REGS],
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              tx_o,
  output logic              tx_en_o
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] tx_byte;
  logic              tx_q, tx_en_q;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  // Receive: byte completes with the bit arriving this clock.
  assign rx_byte_o = {rx_sh, rx_i};

  // Output owner for the current slot; lowest register index wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = NUM_REGS - 1; k >= 0; k--) begin
      if (out_en_i[k] && sel_i[k][SEL_W-1] == LINE_ID &&
          sel_i[k][SLOT_W-1:0] == slot_i) begin
        hit = 1'b1;
        idx = IDX_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh   <= '0;
      tx_byte <= '0;
      tx_q    <= 1'b0;
      tx_en_q <= 1'b0;
    end else begin
      rx_sh   <= {rx_sh[DATA_W-3:0], rx_i};
      tx_en_q <= hit;
      if (hit && bit_i == '0) begin
        tx_byte <= data_i[idx];
        tx_q    <= data_i[idx][DATA_W-1];
      end else if (hit) begin
        tx_q    <= tx_byte[BIT_W'(DATA_W - 1) - bit_i];
      end else begin
        tx_q    <= 1'b0;
      end
    end
  end

  assign tx_o    = tx_q;
  assign tx_en_o = tx_en_q;

endmodule

// File: rtl/tdm_sa_regs.sv
module tdm_sa_regs
  import tdm_sa_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 5,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic [NUM_REGS-1:0] cap_en_i,
  input  logic [DATA_W-1:0] cap_byte_i [NUM_REGS],
  output logic [DATA_W-1:0] data_o [NUM_REGS],
  output logic [SEL_W-1:0]  sel_o [NUM_REGS],
  output pair_ctrl_t        ctrl_o [NUM_PAIRS],
  output logic [DATA_W-1:0] cpu_rdata_o
);

  logic [DATA_W-1:0] data_q [NUM_REGS];
  logic [SEL_W-1:0]  sel_q  [NUM_REGS];
  pair_ctrl_t        ctrl_q [NUM_PAIRS];
  logic [DATA_W-1:0] rd_n, rd_q;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[k] <= '0;
        sel_q[k]  <= '0;
      end else begin
        // Microcontroller write outranks a same-cycle capture.
        if (cpu_wr_i && cpu_addr_i == ADDR_W'(k))
          data_q[k] <= cpu_wdata_i;
        else if (cap_en_i[k])
          data_q[k] <= cap_byte_i[k];
        if (cpu_wr_i && cpu_addr_i == ADDR_W'(NUM_REGS + k))
          sel_q[k] <= cpu_wdata_i[SEL_W-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst)
        ctrl_q[p] <= '0;
      else if (cpu_wr_i && cpu_addr_i == ADDR_W'(2 * NUM_REGS + p))
        ctrl_q[p] <= pair_ctrl_t'(cpu_wdata_i[CTRL_W-1:0]);
    end
  end

  always_comb begin
    rd_n = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (cpu_addr_i == ADDR_W'(k))
        rd_n = data_q[k];
      if (cpu_addr_i == ADDR_W'(NUM_REGS + k))
        rd_n[SEL_W-1:0] = sel_q[k];
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (cpu_addr_i == ADDR_W'(2 * NUM_REGS + p))
        rd_n[CTRL_W-1:0] = ctrl_q[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign data_o      = data_q;
  assign sel_o       = sel_q;
  assign ctrl_o      = ctrl_q;
  assign cpu_rdata_o = rd_q;

endmodule

// File: rtl/tdm_slot_access.sv
module tdm_slot_access
  import tdm_sa_pkg::*;
#(
  parameter int SLOTS     = 12,
  parameter int DATA_W    = 8,
  parameter int NUM_PAIRS = 2,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              up_rx,
  input  logic              dn_rx,
  output logic              up_tx,
  output logic              up_tx_en,
  output logic              dn_tx,
  output logic              dn_tx_en,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);

  localparam int NUM_REGS = 2 * NUM_PAIRS;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int BIT_W    = $clog2(DATA_W);
  localparam int SEL_W    = SLOT_W + 1;

  logic [SLOT_W-1:0]   cur_slot;
  logic [BIT_W-1:0]    cur_bit;
  logic                last_bit;
  logic [DATA_W-1:0]   data_q   [NUM_REGS];
  logic [SEL_W-1:0]    sel_q    [NUM_REGS];
  pair_ctrl_t          ctrl_q   [NUM_PAIRS];
  logic [NUM_REGS-1:0] cap_en;
  logic [DATA_W-1:0]   cap_byte [NUM_REGS];
  logic [NUM_REGS-1:0] out_en;
  logic                rx_bit   [2];
  logic [DATA_W-1:0]   rx_byte  [2];
  logic                tx_bit   [2];
  logic                tx_en    [2];

  tdm_sa_frame_timer #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
  ) u_timer (
    .clk(clk), .rst(rst), .fsync_i(fsync),
    .slot_o(cur_slot), .bit_o(cur_bit), .last_bit_o(last_bit)
  );

  tdm_sa_regs #(
    .NUM_PAIRS(NUM_PAIRS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cap_en_i(cap_en), .cap_byte_i(cap_byte),
    .data_o(data_q), .sel_o(sel_q), .ctrl_o(ctrl_q),
    .cpu_rdata_o(cpu_rdata)
  );

  // Capture steering: swap borrows the partner's input selection.
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_cap
    localparam int P = k / 2;
    localparam int M = k % 2;
    logic [SEL_W-1:0] in_sel;
    logic             in_en;

    assign in_sel    = ctrl_q[P].swap ? sel_q[k ^ 1] : sel_q[k];
    assign in_en     = (M == 0) ? ctrl_q[P].in0  : ctrl_q[P].in1;
    assign out_en[k] = (M == 0) ? ctrl_q[P].out0 : ctrl_q[P].out1;
    assign cap_en[k] = in_en && last_bit && (in_sel[SLOT_W-1:0] == cur_slot);
    assign cap_byte[k] = in_sel[SEL_W-1] ? rx_byte[LINE_DN] : rx_byte[LINE_UP];
  end

  assign rx_bit[LINE_UP] = up_rx;
  assign rx_bit[LINE_DN] = dn_rx;

  for (genvar l = 0; l < 2; l++) begin : g_line
    tdm_sa_line #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SLOT_W(SLOT_W),
      .BIT_W(BIT_W), .SEL_W(SEL_W), .LINE_ID(l[0])
    ) u_line (
      .clk(clk), .rst(rst), .rx_i(rx_bit[l]),
      .slot_i(cur_slot), .bit_i(cur_bit),
      .sel_i(sel_q), .out_en_i(out_en), .data_i(data_q),
      .rx_byte_o(rx_byte[l]), .tx_o(tx_bit[l]), .tx_en_o(tx_en[l])
    );
  end

  assign up_tx    = tx_bit[LINE_UP];
  assign up_tx_en = tx_en[LINE_UP];
  assign dn_tx    = tx_bit[LINE_DN];
  assign dn_tx_en = tx_en[LINE_DN];

endmodule

// File: rtl/tdm_slot_access_chk.sv
module tdm_slot_access_chk
  import tdm_sa_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 8,
  parameter int SLOT_W    = 4,
  parameter int BIT_W     = 3,
  parameter int ADDR_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fsync,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              up_tx_en,
  input logic              dn_tx_en,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [BIT_W-1:0]  cur_bit,
  input logic [DATA_W-1:0] data_i [NUM_REGS],
  input pair_ctrl_t        ctrl_i [NUM_PAIRS]
);

  // R1: the bit after a frame start is bit 1 of slot 0.
  assert_frame_step_R1: assert property (@(posedge clk) disable iff (rst)
    fsync ##1 !fsync |-> (cur_slot == '0 && cur_bit == BIT_W'(1)));

  // R10: reset leaves both lines undriven and read data cleared.
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!up_tx_en && !dn_tx_en && cpu_rdata == '0));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_k
    localparam int P = k / 2;
    localparam int M = k % 2;

    // R9: a write always lands, even against a capture.
    assert_cpu_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && cpu_addr == ADDR_W'(k)) |=> data_i[k] == $past(cpu_wdata));

    // R6: with input disabled and no write, the data register holds.
    assert_input_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!((M == 0) ? ctrl_i[P].in0 : ctrl_i[P].in1) &&
       !(cpu_wr && cpu_addr == ADDR_W'(k))) |=> $stable(data_i[k]));

    // R8: a data register read returns its value one clock later.
    assert_read_data_R8: assert property (@(posedge clk) disable iff (rst)
      (cpu_addr == ADDR_W'(k)) |=> cpu_rdata == $past(data_i[k]));
  end

endmodule

bind tdm_slot_access tdm_slot_access_chk #(
  .NUM_PAIRS(NUM_PAIRS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
  .SLOT_W(SLOT_W), .BIT_W(BIT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata), .up_tx_en(up_tx_en), .dn_tx_en(dn_tx_en),
  .cur_slot(cur_slot), .cur_bit(cur_bit),
  .data_i(data_q), .ctrl_i(ctrl_q)
);

// File: tb/tdm_slot_access_tb.sv
module tdm_slot_access_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0, up_rx = 1'b0, dn_rx = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       up_tx, up_tx_en, dn_tx, dn_tx_en;
  logic [7:0] cpu_rdata;

  tdm_slot_access u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .up_rx(up_rx), .dn_rx(dn_rx),
    .up_tx(up_tx), .up_tx_en(up_tx_en), .dn_tx(dn_tx), .dn_tx_en(dn_tx_en),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, frame_cnt = 0, drv_now = 0;
  logic [7:0] frm    [2][12];
  logic [7:0] live_d [2][12];
  logic [7:0] live_e [2][12];
  logic [7:0] snap_d [2][12];
  logic [7:0] snap_e [2][12];

  // Vector: [20] swap, [19:18] reg, [17:13] own select, [12:8] partner select, [7:0] byte
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 2'd0, 5'h03, 5'h0F, 8'hA5},
    {1'b0, 2'd3, 5'h1B, 5'h0F, 8'h3C},
    {1'b1, 2'd1, 5'h10, 5'h07, 8'hC3},
    {1'b1, 2'd2, 5'h05, 5'h12, 8'h5A},
    {1'b0, 2'd1, 5'h00, 5'h00, 8'h81},
    {1'b0, 2'd2, 5'h0D, 5'h00, 8'h77}
  };

  // Bus driver and line recorder. Outputs seen now belong to the previous position.
  initial begin
    int pos = 0, last = 0;
    bit rec = 0;
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 12; s++) begin
        frm[l][s] = '0; live_d[l][s] = '0; live_e[l][s] = '0;
      end
    forever begin
      @(negedge clk);
      if (rec) begin
        live_d[0][last/8][7-last%8] = up_tx;
        live_e[0][last/8][7-last%8] = up_tx_en;
        live_d[1][last/8][7-last%8] = dn_tx;
        live_e[1][last/8][7-last%8] = dn_tx_en;
      end
      if (pos == 0) begin
        snap_d = live_d;
        snap_e = live_e;
        frame_cnt++;
      end
      fsync   = (pos == 0);
      up_rx   = frm[0][pos/8][7-pos%8];
      dn_rx   = frm[1][pos/8][7-pos%8];
      drv_now = pos;
      last    = pos;
      rec     = 1;
      pos     = (pos == 95) ? 0 : pos + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    cpu_addr = a[3:0]; cpu_wdata = d[7:0]; cpu_wr = 1'b1;
    @(negedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); #1;
    cpu_addr = a[3:0];
    @(negedge clk); #1;
    d = int'(cpu_rdata);
  endtask

  task automatic wait_frames(input int n);
    int t = frame_cnt;
    wait (frame_cnt >= t + n);
  endtask

  task automatic base_frames();
    for (int s = 0; s < 12; s++) begin
      frm[0][s] = 8'h10 + 8'(s);
      frm[1][s] = 8'hA0 + 8'(s);
    end
  endtask

  task automatic clear_cfg();
    wr(8, 0); wr(9, 0);
    for (int k = 0; k < 4; k++) wr(4 + k, 15);
    for (int k = 0; k < 4; k++) wr(k, 0);
  endtask

  // Compares the last full frame on both lines; slot < 0 means all idle.
  task automatic check_out(input string req, input int line, input int slot, input int byt);
    int act = 0, exp = 0;
    bit bad = 0;
    string what = "frame output";
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 12; s++) begin
        logic [7:0] ee, ed;
        ee = (l == line && s == slot) ? 8'hFF : 8'h00;
        ed = (ee != 0) ? byt[7:0] : 8'h00;
        if (!bad && (snap_e[l][s] !== ee || snap_d[l][s] !== ed)) begin
          bad  = 1;
          act  = {16'h0, snap_e[l][s], snap_d[l][s]};
          exp  = {16'h0, ee, ed};
          what = $sformatf("line %0d slot %0d {en,data}", l, s);
        end
      end
    check(req, what, act, exp);
  endtask

  initial begin
    int d;
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    // R10: reset state
    check("R10", "up drive enable after reset", int'(up_tx_en), 0);
    check("R10", "dn drive enable after reset", int'(dn_tx_en), 0);
    rd(0, d); check("R10", "data reg 0 after reset", d, 0);
    rd(8, d); check("R10", "pair 1 control after reset", d, 0);

    // R8: register map widths and unused offsets
    wr(5, 8'h3B); rd(5, d); check("R8", "select reg keeps 5 bits", d, 8'h1B);
    wr(9, 8'hFF); rd(9, d); check("R8", "control keeps 5 bits", d, 8'h1F);
    rd(12, d); check("R8", "unused offset reads 0", d, 0);

    // Table of loop, swap and boundary vectors: R1 R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      logic       sw;
      logic [1:0] k;
      logic [4:0] sk, sp, src;
      logic [7:0] b;
      string tag;
      {sw, k, sk, sp, b} = VEC[i];
      clear_cfg();
      base_frames();
      src = sw ? sp : sk;
      if (src[3:0] < 12) frm[src[4]][src[3:0]] = b;
      wr(4 + int'(k), int'(sk));
      wr(4 + int'(k ^ 2'd1), int'(sp));
      wr(8 + int'(k) / 2, int'(sw) | (1 << (1 + int'(k) % 2)) | (1 << (3 + int'(k) % 2)));
      wait_frames(3);
      tag = (sk[3:0] >= 12) ? "R2" : (sw ? "R4 R1 R5" : "R3 R1 R5");
      if (sk[3:0] < 12) check_out(tag, int'(sk[4]), int'(sk[3:0]), int'(b));
      else              check_out(tag, -1, -1, 0);
      rd(int'(k), d);
      check(tag, $sformatf("vector %0d data readback", i), d,
            (src[3:0] < 12) ? int'(b) : 0);
    end

    // R6: input disable holds the old byte
    clear_cfg(); base_frames();
    frm[0][4] = 8'h66;
    wr(4, 8'h04); wr(8, 8'h0A);
    wait_frames(3);
    wr(8, 8'h08);
    frm[0][4] = 8'h99;
    wait_frames(3);
    rd(0, d); check("R6", "held data after input disable", d, 8'h66);
    check_out("R6", 0, 4, 8'h66);

    // R7: output disable, capture continues
    wr(8, 8'h02);
    wait_frames(3);
    check_out("R7", -1, -1, 0);
    rd(0, d); check("R7", "capture with output off", d, 8'h99);

    // R9: write collides with capture at slot 4 bit 7
    forever begin
      @(negedge clk); #1;
      if (drv_now == 39) break;
    end
    cpu_addr = 4'd0; cpu_wdata = 8'h42; cpu_wr = 1'b1;
    @(negedge clk); #1 cpu_wr = 1'b0;
    @(negedge clk); #1;
    check("R9", "write wins over capture", int'(cpu_rdata), 8'h42);

    // R8: software-written byte is driven out
    clear_cfg(); base_frames();
    wr(5, 8'h16); wr(1, 8'hE7); wr(8, 8'h10);
    wait_frames(3);
    check_out("R8", 1, 6, 8'hE7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule